// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller lets a synchronous host reach an external asynchronous static RAM that is 16 bits wide, addressed by 20 bits, and split into two byte lanes. The host raises a request carrying an address, a write flag, two byte-enable bits and write data. While the controller is idle and ready, that request is accepted on a clock edge. The controller then plays out the memory-side pin sequence. The interval lengths are counted in clocks, each one the minimum time of the part divided by the clock period and rounded up.

A read keeps the RAM selected with output enable low for the access window. The returned word is captured on the last clock of that window and shown for one cycle with a valid pulse. A write keeps write enable low long enough to meet both the pulse width and the data setup time, then leaves the part deselected for a recovery interval, and ends with a one-cycle done pulse. After every read the controller waits a turnaround gap before its own data drivers may switch on. Output enable is never low while those drivers are on. Between accesses the RAM is left deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: Outside an access phase (idle, write recovery, read recovery, reset) the chip is deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, both lane selects high. During the read-access and write-pulse phases `mem_ce1_n`=0 and `mem_ce2`=1.
- R2: During a read access `mem_we_n`=1, `mem_oe_n`=0 and `mem_dq_oe`=0. `mem_lb_n` is the inverse of `req_be[0]` (bits 7:0) and `mem_ub_n` is the inverse of `req_be[1]` (bits 15:8).
- R3: During a write pulse `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_dq_out` equal to the request's write data and the lane selects set as in R2. A lane whose enable bit is 0 keeps its old contents, including when both bits are 0.
- R4: `mem_addr` equals the accepted address in every clock from acceptance until the controller is idle again, so it never moves while write enable is low.
- R5: Write enable stays low for max(ceil(T_WP/T), ceil(T_DS/T)) clocks, which is 10 at the defaults. Write data is driven for that whole pulse and for the recovery that follows.
- R6: Read data is sampled max(ceil(T_AA/T), ceil(T_RC/T), ceil(T_OE/T)) clocks after the read pins are applied, which is 14 at the defaults and at least T_AA. It appears on `rd_data` with a one-cycle `rd_valid` in the next cycle. Lanes not enabled read as zero.
- R7: A write occupies at least ceil(T_RC/T) clocks from acceptance to idle. Its recovery lasts max(1, ceil(T_RC/T) − pulse length) clocks.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays 0 for at least T_FLOAT.
- R9: `req_ready` is 1 exactly when the controller is idle. `wr_done` is a one-cycle pulse in the first idle cycle after a write's recovery ends.
- R10: Under reset the memory pins take the deselected values of R1, `mem_dq_oe`=0, and `rd_valid`=`wr_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; the request is accepted at this edge |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_be | input | 2 | Lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Captured read word, with disabled lanes zeroed |
| wr_done | output | 1 | One-cycle write completion strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low lower-lane select |
| mem_ub_n | output | 1 | Active-low upper-lane select |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 16 | Data read back from the memory |

## Verification
The bench uses the default parameters: a 5 ns period with 50/30/70/70/50/30 ns minimum times. With these values the write pulse is 10 clocks, the write recovery 4, the read window 14 and the turnaround 6. None of these counts collapses to one, so an off-by-one in any interval shows up as a pin-level mismatch. The bench's RAM model drives a float pattern on deselected lanes and commits writes only when write enable rises. This makes lane masking, writes with no lane enabled, and a write issued straight after a read visible at the ports.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int ADDR_W        = 20,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_WP_NS       = 50,
  parameter int T_DS_NS       = 30,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 50,
  parameter int T_RC_NS       = 70,
  parameter int T_FLOAT_NS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [15:0]       req_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int C_WP  = (T_WP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_DS  = (T_DS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_AA  = (T_AA_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_OE  = (T_OE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_RC  = (T_RC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_FL  = (T_FLOAT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WR_LEN   = (C_WP > C_DS) ? C_WP : C_DS;
  localparam int WREC_LEN = (C_RC > WR_LEN) ? C_RC - WR_LEN : 1;
  localparam int RD_A     = (C_AA > C_RC) ? C_AA : C_RC;
  localparam int RD_LEN   = (RD_A > C_OE) ? RD_A : C_OE;
  localparam int TA_LEN   = (C_FL > 1) ? C_FL : 1;
  localparam int MAX_A    = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
  localparam int MAX_B    = (WREC_LEN > TA_LEN) ? WREC_LEN : TA_LEN;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WREC, S_RD, S_RREC} state_t;

  state_t          state, nxt;
  logic [CW-1:0]   cnt, nxt_len;
  logic [1:0]      be_q, nxt_be;
  logic            acc;
  wire             last = (cnt == '0);

  assign req_ready = (state == S_IDLE);
  assign nxt_be    = (state == S_IDLE) ? req_be : be_q;
  assign acc       = (nxt == S_WR) || (nxt == S_RD);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (req_valid) nxt = req_write ? S_WR : S_RD;
      S_WR:    if (last) nxt = S_WREC;
      S_WREC:  if (last) nxt = S_IDLE;
      S_RD:    if (last) nxt = S_RREC;
      S_RREC:  if (last) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    case (nxt)
      S_WR:    nxt_len = CW'(WR_LEN - 1);
      S_WREC:  nxt_len = CW'(WREC_LEN - 1);
      S_RD:    nxt_len = CW'(RD_LEN - 1);
      S_RREC:  nxt_len = CW'(TA_LEN - 1);
      default: nxt_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      be_q       <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      wr_done    <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      state    <= nxt;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      if (state != nxt)    cnt <= nxt_len;
      else if (!last)      cnt <= cnt - 1'b1;
      if (state == S_IDLE && req_valid) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        be_q       <= req_be;
      end
      if (state == S_RD && last) begin
        rd_data  <= mem_dq_in & {{8{be_q[1]}}, {8{be_q[0]}}};
        rd_valid <= 1'b1;
      end
      if (state == S_WREC && last) wr_done <= 1'b1;
      mem_ce1_n <= !acc;
      mem_ce2   <= acc;
      mem_we_n  <= (nxt != S_WR);
      mem_oe_n  <= (nxt != S_RD);
      mem_lb_n  <= !(acc && nxt_be[0]);
      mem_ub_n  <= !(acc && nxt_be[1]);
      mem_dq_oe <= (nxt == S_WR) || (nxt == S_WREC);
    end
  end

  logic [CW:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        we_run <= '0;
    else if (mem_we_n) we_run <= '0;
    else               we_run <= we_run + 1'b1;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= (CW+1)'(WR_LEN))); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R9
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n)); // R1
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int T    = 5;
  localparam int WP_C = (50 + T - 1) / T;
  localparam int DS_C = (30 + T - 1) / T;
  localparam int RC_C = (70 + T - 1) / T;
  localparam int AA_C = (70 + T - 1) / T;
  localparam int WRL  = (WP_C > DS_C) ? WP_C : DS_C;
  localparam int WREC = (RC_C > WRL) ? RC_C - WRL : 1;
  localparam int RDL  = (AA_C > RC_C) ? AA_C : RC_C;
  localparam int TA   = (30 + T - 1) / T;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rd_valid, wr_done;
  logic [15:0] rd_data, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  sram_async_ctrl dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  always #2.5 clk = ~clk;

  logic [15:0] sram [0:255];
  logic [15:0] ref_mem [0:255];
  wire sel = !mem_ce1_n && mem_ce2;
  assign mem_dq_in = (sel && mem_we_n && !mem_oe_n) ?
    {mem_ub_n ? 8'hEE : sram[mem_addr[7:0]][15:8], mem_lb_n ? 8'hEE : sram[mem_addr[7:0]][7:0]} : 16'hEEEE;

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  int mk = 0, mrem = 0;
  bit acc_pend = 0;
  logic [19:0] m_addr; logic [1:0] m_be; logic [15:0] m_wd, m_exp; bit m_wr;
  logic p_sel = 0, p_we = 1, p_oe = 1, p_lb = 1, p_ub = 1, p_dqoe = 0;
  logic [19:0] p_addr = 0; logic [15:0] p_dq = 0;
  int we_low = 0, oe_gap = 100, stab = 0, p_stab = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && !wr_done,
          "R10 reset pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, wr_done}, 7'b1011000);
    end else begin
      bit ev_rd, ev_wr;
      ev_rd = 0; ev_wr = 0;
      if (p_sel && !p_we && (!sel || mem_we_n)) begin
        if (!p_lb) sram[p_addr[7:0]][7:0]  = p_dq[7:0];
        if (!p_ub) sram[p_addr[7:0]][15:8] = p_dq[15:8];
        chk(p_dqoe, "R3 drivers on at write end", p_dqoe, 1);
      end
      if (!mem_we_n) we_low++;
      else begin
        if (!p_we) chk(we_low >= WRL && we_low * T >= 50, "R5 we low width", we_low, WRL);
        we_low = 0;
      end
      if (!mem_oe_n) oe_gap = 0; else if (oe_gap < 100) oe_gap++;
      if (!p_dqoe && mem_dq_oe) chk(oe_gap * T >= 30, "R8 turnaround gap", oe_gap, TA);
      chk(!(mem_dq_oe && !mem_oe_n), "R8 no contention", {mem_dq_oe, mem_oe_n}, 2'b01);
      p_stab = stab;
      if (mem_addr != p_addr || mem_oe_n != p_oe || mem_lb_n != p_lb || mem_ub_n != p_ub) stab = 0;
      else stab++;

      if (acc_pend) begin
        mk = m_wr ? 1 : 3; mrem = m_wr ? WRL : RDL; acc_pend = 0;
      end else if (mk != 0) begin
        mrem--;
        if (mrem == 0) case (mk)
          1: begin mk = 2; mrem = WREC; end
          2: begin mk = 0; ev_wr = 1; end
          3: begin mk = 4; mrem = TA; ev_rd = 1; end
          default: mk = 0;
        endcase
      end
      chk(rd_valid == ev_rd, "R6 rd_valid pulse", rd_valid, ev_rd);
      chk(wr_done == ev_wr, "R9 wr_done pulse", wr_done, ev_wr);
      if (ev_rd) begin
        chk(rd_data == m_exp, "R6 read data", rd_data, m_exp);
        chk((p_stab + 1) * T >= 70, "R6 access time", p_stab + 1, RDL);
      end
      chk(req_ready == (mk == 0), "R9 ready only idle", req_ready, mk == 0);
      case (mk)
        1: chk(!mem_ce1_n && mem_ce2 && !mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == m_addr &&
               mem_dq_out == m_wd && mem_lb_n == !m_be[0] && mem_ub_n == !m_be[1],
               "R3 write pulse pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, mem_lb_n, mem_ub_n}, {5'b01011, !m_be[0], !m_be[1]});
        2: chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == m_addr && mem_dq_out == m_wd,
               "R7 write recovery pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10111);
        3: chk(!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n && !mem_dq_oe && mem_addr == m_addr &&
               mem_lb_n == !m_be[0] && mem_ub_n == !m_be[1],
               "R2 read pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, mem_lb_n, mem_ub_n}, {5'b01100, !m_be[0], !m_be[1]});
        4: chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_addr == m_addr,
               "R4 read recovery pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        default: chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
               "R1 idle pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 7'b1011110);
      endcase
      if (mk == 0 && req_valid) begin
        acc_pend = 1; m_addr = req_addr; m_be = req_be; m_wd = req_wdata; m_wr = req_write;
        if (req_write) begin
          if (req_be[0]) ref_mem[req_addr[7:0]][7:0]  = req_wdata[7:0];
          if (req_be[1]) ref_mem[req_addr[7:0]][15:8] = req_wdata[15:8];
        end else
          m_exp = ref_mem[req_addr[7:0]] & {{8{req_be[1]}}, {8{req_be[0]}}};
      end
    end
    p_sel = sel; p_we = mem_we_n; p_oe = mem_oe_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
    p_dqoe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  task automatic xfer(input bit wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i] = {8'(i) ^ 8'h5A, 8'(i)};
      ref_mem[i] = sram[i];
    end
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1;
    xfer(1, 20'h00012, 2'b11, 16'h1234);             // R3 full write
    xfer(0, 20'h00012, 2'b11, 16'h0);                // R6 readback
    xfer(1, 20'h00034, 2'b01, 16'hABCD);             // R3 lower lane only
    xfer(0, 20'h00034, 2'b11, 16'h0);
    xfer(1, 20'h00034, 2'b10, 16'h5566);             // R3 upper lane only
    xfer(0, 20'h00034, 2'b01, 16'h0);                // R6 upper lane zeroed
    xfer(1, 20'h00056, 2'b00, 16'hFFFF);             // R3 no lane enabled
    xfer(0, 20'h00056, 2'b11, 16'h0);
    xfer(0, 20'hFFFFF, 2'b10, 16'h0);                // R6 lower lane zeroed
    xfer(1, 20'hFFFFF, 2'b11, 16'h9A9A);             // R8 write right after read
    xfer(0, 20'hFFFFF, 2'b11, 16'h0);
    for (int i = 0; i < 8; i++) begin
      xfer(1, 20'h30080 + 20'(i), 2'(i % 4), 16'(i * 16'h1111 + 16'h0F0F));
      xfer(0, 20'h30080 + 20'(i), 2'b11, 16'h0);
    end
    repeat (RDL + TA + 4) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * T);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule